// File: doc/BRIEF.md
# LED Dimmer Configuration Target on a Two-Wire Serial Bus

This block is a serial-bus target that holds the configuration of a small LED dimmer. A bus controller reaches it with one fixed 7-bit address. The first byte written after the address is a control byte. That byte selects one of six byte-wide registers and can turn on automatic stepping of the register index. The block presents the two blink-rate prescalers, the two duty values and the LED selector as plain outputs, which a neighbouring PWM engine reads. It also returns the present level of the four LED pins through a read-only register.

The bus lines are sampled with the system clock. The clock must run fast enough that each low and high phase of SCL lasts several clock cycles. SDA is open drain: `sda_oe_o` high means the block pulls the line low. No clock stretching is done. Because every bus byte moves with a fixed bit timing set by the controller, there is no valid/ready stream at the edge. All pins are plain control or status signals.

Top module: `ledi2c_target`

## Requirements
- R1: With `VARIANT`=0 the block answers address 7'b1100010, and with `VARIANT`=1 it answers 7'b1100011. The eighth address bit set to 1 means read and set to 0 means write. A matching address is acknowledged. Any other address gets no acknowledge, and the block then leaves SDA alone until the next START.
- R2: In the control byte, bit 4 enables auto-increment and bits 2..0 hold the register index. All other bits are ignored. The control state resets to index 0 with auto-increment off.
- R3: The index map is 0 = pin levels, 1 = rate0, 2 = duty0, 3 = rate1, 4 = duty1, 5 = LED selector. An acknowledged data byte written to indices 1..5 appears on the matching output.
- R4: After reset, rate0 and rate1 read 00h, duty0 and duty1 read 80h, and the selector reads 00h. LED k owns selector bits 2k+1..2k, and code 00 means the LED is off.
- R5: With auto-increment on, the index advances after every data byte that is read or written, and indices 5, 6 and 7 step to 0. With auto-increment off, the index does not move.
- R6: Index 0 reads as {4'b0000, pin levels}. A write to it is acknowledged and changes no register.
- R7: Indices 6 and 7 read as 00h. Writes to them are acknowledged and dropped.
- R8: A repeated START keeps the index, so a write that sets the index can be followed by a read from that index.
- R9: During a read, once the controller does not acknowledge a byte, the block stops driving SDA until the next START.
- R10: SDA driven by the block changes only while SCL is low. Register outputs also change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | High pulls SDA low |
| pin_lvl_i | input | NUM_PINS | Present LED pin levels |
| rate0_o | output | 8 | Prescaler 0 |
| duty0_o | output | 8 | Duty value 0 |
| rate1_o | output | 8 | Prescaler 1 |
| duty1_o | output | 8 | Duty value 1 |
| led_sel_o | output | 8 | LED selector, 2 bits per LED |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except to form START and STOP. They also assume that each SCL phase lasts longer than the input synchronizer delay, and that no START or STOP arrives while the block is driving an acknowledge or data bit. The bench keeps within these limits. Its bus tasks hold every quarter bit for eight clock cycles, change data only in the low phase, and issue START and STOP only while the block has released SDA. Two instances share one bus, so one instance sees a foreign address whenever the other is addressed.

// File: rtl/ledi2c_pkg.sv
package ledi2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 3;
  localparam int REG_CNT = 6;
  localparam int AI_BIT  = 4;
  localparam logic [6:0] ADDR_BASE = 7'b1100010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_ADDR, RX_CTRL, RX_DATA
  } rx_role_e;

  // reset value of a stored register by index
  function automatic logic [BYTE_W-1:0] reset_value(input int idx);
    if (idx == 2 || idx == 4) return 8'h80;
    return 8'h00;
  endfunction

  // index stepping: last map entry and anything beyond wrap to zero
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    if (p >= PTR_W'(REG_CNT - 1)) return '0;
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/ledi2c_sync.sv
module ledi2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
      scl_q    <= scl_pipe[LAST];
      sda_q    <= sda_pipe[LAST];
    end
  end

  assign scl_s     = scl_pipe[LAST];
  assign sda_s     = sda_pipe[LAST];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ledi2c_regfile.sv
module ledi2c_regfile
  import ledi2c_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PTR_W-1:0]    wr_idx,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [PTR_W-1:0]    rd_idx,
  input  logic [NUM_PINS-1:0] pins,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [BYTE_W-1:0]   rate0,
  output logic [BYTE_W-1:0]   duty0,
  output logic [BYTE_W-1:0]   rate1,
  output logic [BYTE_W-1:0]   duty1,
  output logic [BYTE_W-1:0]   sel
);
  localparam int PAD = BYTE_W - NUM_PINS;

  logic [BYTE_W-1:0] store [1:REG_CNT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < REG_CNT; k++) store[k] <= reset_value(k);
    end else if (wr_en) begin
      for (int k = 1; k < REG_CNT; k++)
        if (wr_idx == PTR_W'(k)) store[k] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == '0) rd_data = {{PAD{1'b0}}, pins};
    else if (rd_idx < PTR_W'(REG_CNT)) rd_data = store[rd_idx];
  end

  assign rate0 = store[1];
  assign duty0 = store[2];
  assign rate1 = store[3];
  assign duty1 = store[4];
  assign sel   = store[5];
endmodule

// File: rtl/ledi2c_link.sv
module ledi2c_link
  import ledi2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1100010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr_o,
  output bus_state_e        state_o
);
  bus_state_e        state;
  rx_role_e          role;
  logic              to_tx;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sr, tx;
  logic [PTR_W-1:0]  ptr;
  logic              ai;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      role    <= RX_ADDR;
      to_tx   <= 1'b0;
      cnt     <= '0;
      sr      <= '0;
      tx      <= '0;
      ptr     <= '0;
      ai      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        role   <= RX_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              sr  <= {sr[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              unique case (role)
                RX_ADDR: begin
                  if (sr[7:1] == SLAVE_ADDR) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    to_tx  <= sr[0];
                    role   <= RX_CTRL;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                RX_CTRL: begin
                  ptr    <= sr[PTR_W-1:0];
                  ai     <= sr[AI_BIT];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  to_tx  <= 1'b0;
                  role   <= RX_DATA;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sr;
                  if (ai) ptr <= next_ptr(ptr);
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                  to_tx   <= 1'b0;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (to_tx) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                if (ai) ptr <= next_ptr(ptr);
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_MACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_SKIP;
            end else if (scl_fall) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              if (ai) ptr <= next_ptr(ptr);
              cnt    <= '0;
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o   = ptr;
  assign state_o = state;
endmodule

// File: rtl/ledi2c_target.sv
module ledi2c_target
  import ledi2c_pkg::*;
#(
  parameter int VARIANT     = 0,
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  output logic [7:0]          rate0_o,
  output logic [7:0]          duty0_o,
  output logic [7:0]          rate1_o,
  output logic [7:0]          duty1_o,
  output logic [7:0]          led_sel_o
);
  localparam logic [6:0] SLAVE_ADDR = ADDR_BASE | 7'(VARIANT & 1);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  bus_state_e        link_state;

  ledi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ledi2c_link #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_o(ptr), .state_o(link_state)
  );

  ledi2c_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr), .pins(pin_lvl_i),
    .rd_data(rd_data), .rate0(rate0_o), .duty0(duty0_o),
    .rate1(rate1_o), .duty1(duty1_o), .sel(led_sel_o)
  );
endmodule

// File: rtl/ledi2c_target_chk.sv
module ledi2c_target_chk
  import ledi2c_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [39:0]      cfg,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_idx,
  input bus_state_e       state
);
  // R10: the data line moves only in the SCL low phase
  assert_oe_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R10 / R3: register outputs update only in the SCL low phase
  assert_cfg_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> !scl_i);

  // R6: a write aimed at the pin register leaves every output alone
  assert_pin_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0) |=> $stable(cfg));

  // R9: after a refused byte or foreign address the line is released
  assert_skip_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  // R1: no drive outside a transaction
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: each accepted byte gives one write strobe
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

bind ledi2c_target ledi2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe_o),
  .cfg({rate0_o, duty0_o, rate1_o, duty1_o, led_sel_o}),
  .wr_en(wr_en), .wr_idx(wr_idx), .state(link_state)
);

// File: tb/ledi2c_target_bench.sv
`timescale 1ns/1ps
module ledi2c_target_bench;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'b1100010;
  localparam logic [6:0] A1 = 7'b1100011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic oe0, oe1;
  logic [7:0] r0, d0, r1, d1, s0;
  logic [7:0] ar0, ad0, ar1, ad1, as0;
  int n_chk = 0, n_fail = 0;
  wire bus_sda = sda_m & ~oe0 & ~oe1;

  always #4 clk = ~clk;

  ledi2c_target #(.VARIANT(0)) u_ledi2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe_o(oe0),
    .pin_lvl_i(4'hA), .rate0_o(r0), .duty0_o(d0), .rate1_o(r1), .duty1_o(d1),
    .led_sel_o(s0));

  ledi2c_target #(.VARIANT(1)) u_alt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe_o(oe1),
    .pin_lvl_i(4'h5), .rate0_o(ar0), .duty0_o(ad0), .rate1_o(ar1), .duty1_o(ad1),
    .led_sel_o(as0));

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~bus_sda; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic early;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; @(negedge clk); early = bus_sda;
      repeat (Q - 1) @(negedge clk); b[i] = bus_sda; qw(); scl_m = 1'b0;
      chk("R10 data steady while SCL high", 40'(early), 40'(b[i]));
    end
    sda_m = ~give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  task automatic cfg_ok(input string req, input logic [39:0] exp);
    chk(req, {r0, d0, r1, d1, s0}, exp);
  endtask

  task automatic t_reset();
    chk("R4 reset values", {r0, d0, r1, d1, s0}, 40'h00_80_00_80_00);
    chk("R4 reset values alt", {ar0, ad0, ar1, ad1, as0}, 40'h00_80_00_80_00);
    chk("R1 no drive after reset", {oe0, oe1}, 2'b00);
  endtask

  task automatic t_foreign_addr();
    logic a;
    bus_start();
    put_byte({7'b1010101, 1'b0}, a); chk("R1 foreign address refused", 40'(a), 0);
    put_byte(8'h11, a); chk("R1 bytes after foreign address refused", 40'(a), 0);
    put_byte(8'h33, a);
    bus_stop();
    cfg_ok("R1 foreign write ignored", 40'h00_80_00_80_00);
  endtask

  task automatic t_burst_write();
    logic a;
    bus_start();
    put_byte({A0, 1'b0}, a); chk("R1 own address acked", 40'(a), 1);
    put_byte(8'h11, a); chk("R2 control byte acked", 40'(a), 1);
    put_byte(8'h21, a); put_byte(8'h42, a); put_byte(8'h63, a);
    put_byte(8'h84, a); put_byte(8'hA5, a);
    chk("R3 data acked", 40'(a), 1);
    bus_stop();
    cfg_ok("R3 R5 burst write lands in map order", 40'h21_42_63_84_A5);
    chk("R1 other variant untouched", {ar0, ad0, ar1, ad1, as0}, 40'h00_80_00_80_00);
  endtask

  task automatic t_read_wrap();
    logic a; logic [7:0] b;
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'h14, a);
    bus_start();
    put_byte({A0, 1'b1}, a); chk("R8 read address acked after repeated START", 40'(a), 1);
    get_byte(1'b1, b); chk("R8 read starts at index set before repeated START", 40'(b), 40'h84);
    get_byte(1'b1, b); chk("R5 read steps to selector", 40'(b), 40'hA5);
    get_byte(1'b1, b); chk("R5 R6 read wraps to pin register", 40'(b), 40'h0A);
    get_byte(1'b0, b); chk("R5 read continues to rate0", 40'(b), 40'h21);
    bus_stop();
  endtask

  task automatic t_pin_write();
    logic a; logic [7:0] b;
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'h00, a);
    put_byte(8'h5F, a); chk("R6 write to pin register acked", 40'(a), 1);
    bus_stop();
    cfg_ok("R6 pin write changes nothing", 40'h21_42_63_84_A5);
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'h00, a);
    bus_start();
    put_byte({A0, 1'b1}, a); get_byte(1'b0, b);
    chk("R6 pin register shows pin levels", 40'(b), 40'h0A);
    bus_stop();
  endtask

  task automatic t_no_ai();
    logic a;
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'hEB, a);
    put_byte(8'h11, a); put_byte(8'h22, a);
    bus_stop();
    cfg_ok("R2 R5 no auto-increment keeps index 3", 40'h21_42_22_84_A5);
  endtask

  task automatic t_high_ptr();
    logic a; logic [7:0] b;
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'h16, a);
    put_byte(8'h77, a); chk("R7 write to index 6 acked", 40'(a), 1);
    put_byte(8'h99, a); put_byte(8'h3C, a);
    bus_stop();
    cfg_ok("R7 R5 index 6 dropped then wraps to 0 then 1", 40'h3C_42_22_84_A5);
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'h07, a);
    bus_start();
    put_byte({A0, 1'b1}, a); get_byte(1'b0, b);
    chk("R7 index 7 reads zero", 40'(b), 40'h00);
    bus_stop();
  endtask

  task automatic t_nack_release();
    logic a; logic [7:0] b;
    bus_start();
    put_byte({A0, 1'b0}, a); put_byte(8'h11, a);
    bus_start();
    put_byte({A0, 1'b1}, a);
    get_byte(1'b0, b); chk("R9 first byte before refusal", 40'(b), 40'h3C);
    get_byte(1'b0, b); chk("R9 no drive after refusal", 40'(b), 40'hFF);
    chk("R9 line released", 40'(oe0), 0);
    bus_stop();
  endtask

  task automatic t_variant();
    logic a;
    bus_start();
    put_byte({A1, 1'b0}, a); chk("R1 variant 1 address acked", 40'(a), 1);
    put_byte(8'h05, a); put_byte(8'h55, a);
    bus_stop();
    chk("R1 variant 1 selector written", 40'(as0), 40'h55);
    chk("R1 variant 0 selector untouched", 40'(s0), 40'hA5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_foreign_addr();
    t_burst_write();
    t_read_wrap();
    t_pin_write();
    t_no_ai();
    t_high_ptr();
    t_nack_release();
    t_variant();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule